// File: doc/BRIEF.md
# Four-Channel Fixed-Priority DMA Controller

This block moves single bytes between a peripheral and memory on behalf of up to four peripherals, so the processor does not have to copy each byte itself. The host programs each channel with a 16-bit start address, a 14-bit count of transfers minus one and a direction bit. It does this through a byte-wide write port while it still owns the bus. A peripheral then raises its request line. The controller asks the processor for the bus with a hold request, waits for hold-acknowledge, and grants the highest-priority armed requester. It then runs a four-cycle byte transfer on the memory and I/O strobes.

After every byte the controller releases the bus by dropping its hold request for at least one cycle. It then arbitrates again, so a higher-priority channel can take over between bytes. The final byte of a channel's block is flagged on a terminal-count output. That channel disarms itself and raises its bit in a status register. The host reads the status register, and the read clears it.

The sequencer has six states. ST_IDLE (bus released) moves to ST_HOLD when an armed channel requests. ST_HOLD (hold requested) goes to ST_T1 on hold-acknowledge with a request still present, returns to ST_IDLE if every request is withdrawn, and otherwise waits. The states then run ST_T1 (address and acknowledge out), ST_T2 and ST_T3 (strobes active) and ST_T4 (strobes released, counters updated), each after the previous one, and ST_T4 returns to ST_IDLE.

Top module: `quad_dma_engine`

## Requirements
- R1: After reset all acknowledges are high, hold_req is low, all four strobes are high, last_xfer is low and a status read returns 0x00.
- R2: A host write with reg_addr = {channel[1:0], sel} goes to the channel's address register (sel=0) or count/control register (sel=1). A shared byte pointer takes the low byte first, then the high byte. In the count high byte, bits 5:0 are count bits 13:8 and bit 7 is the direction (1: memory read plus I/O write, 0: I/O read plus memory write). Writing that byte arms the channel. A status read resets the byte pointer to the low byte.
- R3: When an armed channel requests, hold_req rises on the next cycle. No acknowledge or strobe is asserted until hold_ack has been sampled high.
- R4: At grant, the lowest-numbered armed requesting channel wins.
- R5: A byte transfer lasts exactly four cycles. The winning channel's chan_ack_n is low and bus_addr holds its address in all four cycles. The direction's read and write strobes are low in the second and third cycles only.
- R6: After the fourth cycle the acknowledge returns high and hold_req is low for at least one cycle.
- R7: Each transfer adds one to the address and subtracts one from the count. A count loaded with n-1 gives exactly n transfers, after which the channel ignores its request.
- R8: last_xfer is high during all four cycles of a channel's last transfer and low during all other transfers.
- R9: Status bit c (bits 3:0) sets when channel c completes its last transfer, and bits 7:4 read as zero. A read (reg_rd) returns the status on reg_rdata on the next cycle and clears it. A bit that sets in the same cycle as the read survives the read.
- R10: Host writes made while hold_req is high are ignored and do not move the byte pointer.
- R11: A request from a channel that has never been armed does not raise hold_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host status read strobe |
| reg_addr | input | 3 | Channel (bits 2:1) and register select (bit 0) |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Status byte, valid the cycle after reg_rd |
| chan_req | input | 4 | Peripheral requests, channel 0 highest priority |
| chan_ack_n | output | 4 | Active-low per-channel acknowledges |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| bus_addr | output | 16 | Memory address during a transfer, zero otherwise |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| io_rd_n | output | 1 | Active-low peripheral read strobe |
| io_wr_n | output | 1 | Active-low peripheral write strobe |
| last_xfer | output | 1 | Terminal count: the current transfer is the channel's last |

## Verification
The functions that can meet in one cycle are the status read and the terminal-count update, which happens on the edge that leaves ST_T4. To provoke the collision, the bench waits until it sees a channel's single armed transfer begin, counts three further cycles, and holds reg_rd high across the ST_T4 cycle. It then expects the read to return the old, empty status and a following read to show the channel's bit still set. A second overlap, a host write landing while the bus is held, is judged by the address of a later transfer and by whether the byte pointer stays aligned.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int DMA_CH_DEF   = 4;
    localparam int DMA_AW_DEF   = 16;
    localparam int DMA_CW_DEF   = 14;
    localparam int DMA_BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_T1   = 3'd2,
        ST_T2   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } dma_state_t;
endpackage

// File: rtl/dma4_prio_pick.sv
module dma4_prio_pick #(
    parameter int N_CH = 4,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] eligible,
    output logic            any_elig,
    output logic [CH_W-1:0] win_idx
);
    // Scan from the lowest priority upward so the lowest index is written last.
    always_comb begin
        any_elig = 1'b0;
        win_idx  = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                any_elig = 1'b1;
                win_idx  = i[CH_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dma4_chan_regs.sv
module dma4_chan_regs #(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    localparam int DW    = 8,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int PAD_W = DW - N_CH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CH_W-1:0]               wr_ch,
    input  logic                          wr_sel,
    input  logic [DW-1:0]                 wr_data,
    input  logic                          rd_en,
    input  logic                          upd,
    input  logic [CH_W-1:0]               upd_ch,
    output logic [N_CH-1:0][ADDR_W-1:0]   ch_addr,
    output logic [N_CH-1:0][CNT_W-1:0]    ch_cnt,
    output logic [N_CH-1:0]               ch_dir,
    output logic [N_CH-1:0]               ch_armed,
    output logic [DW-1:0]                 rdata
);
    logic            hi_sel;
    logic [N_CH-1:0] tc_flags;
    logic [N_CH-1:0] tc_set;
    logic            unused_bits;

    assign unused_bits = ^wr_data[DW-2:CNT_W-DW];

    // Shared byte pointer: toggles per accepted write, reset by a status read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_sel <= 1'b0;
        end else if (rd_en) begin
            hi_sel <= 1'b0;
        end else if (wr_en) begin
            hi_sel <= ~hi_sel;
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        logic [ADDR_W-1:0] addr_q;
        logic [CNT_W-1:0]  cnt_q;
        logic              dir_q;
        logic              armed_q;
        logic              hit_wr;
        logic              hit_upd;

        assign hit_wr  = wr_en && (wr_ch == c[CH_W-1:0]);
        assign hit_upd = upd && (upd_ch == c[CH_W-1:0]);
        assign tc_set[c] = hit_upd && (cnt_q == '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q  <= '0;
                cnt_q   <= '0;
                dir_q   <= 1'b0;
                armed_q <= 1'b0;
            end else if (hit_upd) begin
                addr_q <= addr_q + 1'b1;
                if (cnt_q == '0) begin
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (hit_wr) begin
                if (!wr_sel) begin
                    if (!hi_sel) begin
                        addr_q[DW-1:0] <= wr_data;
                    end else begin
                        addr_q[ADDR_W-1:DW] <= wr_data[ADDR_W-DW-1:0];
                    end
                end else begin
                    if (!hi_sel) begin
                        cnt_q[DW-1:0] <= wr_data;
                    end else begin
                        cnt_q[CNT_W-1:DW] <= wr_data[CNT_W-DW-1:0];
                        dir_q   <= wr_data[DW-1];
                        armed_q <= 1'b1;
                    end
                end
            end
        end

        assign ch_addr[c]  = addr_q;
        assign ch_cnt[c]   = cnt_q;
        assign ch_dir[c]   = dir_q;
        assign ch_armed[c] = armed_q;
    end

    // A read clears the flags, but a flag set in the same cycle survives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_flags <= '0;
            rdata    <= '0;
        end else begin
            tc_flags <= (rd_en ? '0 : tc_flags) | tc_set;
            if (rd_en) begin
                rdata <= {{PAD_W{1'b0}}, tc_flags};
            end
        end
    end
endmodule

// File: rtl/dma4_xfer_fsm.sv
module dma4_xfer_fsm
    import dma4_pkg::*;
#(
    parameter int N_CH = 4,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pending,
    input  logic            hold_ack,
    input  logic [CH_W-1:0] win_idx,
    output dma_state_t      state,
    output logic [CH_W-1:0] cur_ch,
    output logic            hold_req,
    output logic            xfer_active,
    output logic            strobe_on,
    output logic            upd
);
    dma_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Winner is frozen at the moment the bus is granted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch <= '0;
        end else if (state == ST_HOLD && hold_ack && pending) begin
            cur_ch <= win_idx;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = pending ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (!pending) begin
                    nxt = ST_IDLE;
                end else if (hold_ack) begin
                    nxt = ST_T1;
                end else begin
                    nxt = ST_HOLD;
                end
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ST_T4;
            ST_T4:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_req    = 1'b0;
        xfer_active = 1'b0;
        strobe_on   = 1'b0;
        upd         = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HOLD: hold_req = 1'b1;
            ST_T1: begin
                hold_req    = 1'b1;
                xfer_active = 1'b1;
            end
            ST_T2, ST_T3: begin
                hold_req    = 1'b1;
                xfer_active = 1'b1;
                strobe_on   = 1'b1;
            end
            ST_T4: begin
                hold_req    = 1'b1;
                xfer_active = 1'b1;
                upd         = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/quad_dma_engine.sv
module quad_dma_engine
    import dma4_pkg::*;
#(
    parameter int N_CH   = DMA_CH_DEF,
    parameter int ADDR_W = DMA_AW_DEF,
    parameter int CNT_W  = DMA_CW_DEF,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int RA_W  = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [N_CH-1:0]   chan_req,
    output logic [N_CH-1:0]   chan_ack_n,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              last_xfer
);
    logic [N_CH-1:0][ADDR_W-1:0] ch_addr;
    logic [N_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [N_CH-1:0]             ch_dir;
    logic [N_CH-1:0]             ch_armed;
    logic [N_CH-1:0]             eligible;
    logic                        any_elig;
    logic [CH_W-1:0]             win_idx;
    logic [CH_W-1:0]             cur_ch;
    dma_state_t                  state;
    logic                        xfer_active;
    logic                        strobe_on;
    logic                        upd;
    logic                        host_wr_ok;
    logic                        cur_dir;

    // Host loses register access while the bus is requested or held.
    assign host_wr_ok = reg_wr && !hold_req;
    assign eligible   = chan_req & ch_armed;

    dma4_chan_regs #(
        .N_CH   (N_CH),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_ok),
        .wr_ch    (reg_addr[RA_W-1:1]),
        .wr_sel   (reg_addr[0]),
        .wr_data  (reg_wdata),
        .rd_en    (reg_rd),
        .upd      (upd),
        .upd_ch   (cur_ch),
        .ch_addr  (ch_addr),
        .ch_cnt   (ch_cnt),
        .ch_dir   (ch_dir),
        .ch_armed (ch_armed),
        .rdata    (reg_rdata)
    );

    dma4_prio_pick #(.N_CH(N_CH)) pick_i (
        .eligible (eligible),
        .any_elig (any_elig),
        .win_idx  (win_idx)
    );

    dma4_xfer_fsm #(.N_CH(N_CH)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending     (any_elig),
        .hold_ack    (hold_ack),
        .win_idx     (win_idx),
        .state       (state),
        .cur_ch      (cur_ch),
        .hold_req    (hold_req),
        .xfer_active (xfer_active),
        .strobe_on   (strobe_on),
        .upd         (upd)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ack
        assign chan_ack_n[c] = !(xfer_active && (cur_ch == c[CH_W-1:0]));
    end

    assign cur_dir   = ch_dir[cur_ch];
    assign bus_addr  = xfer_active ? ch_addr[cur_ch] : '0;
    assign last_xfer = xfer_active && (ch_cnt[cur_ch] == '0);
    assign mem_rd_n  = !(strobe_on && cur_dir);
    assign io_wr_n   = !(strobe_on && cur_dir);
    assign io_rd_n   = !(strobe_on && !cur_dir);
    assign mem_wr_n  = !(strobe_on && !cur_dir);
endmodule

// File: rtl/dma4_checker.sv
module dma4_checker #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_rd,
    input logic [7:0]      reg_rdata,
    input logic [N_CH-1:0] chan_ack_n,
    input logic            hold_req,
    input logic            mem_rd_n,
    input logic            mem_wr_n,
    input logic            io_rd_n,
    input logic            io_wr_n,
    input logic            last_xfer
);
    logic any_ack;
    logic any_strobe;
    assign any_ack    = (chan_ack_n != {N_CH{1'b1}});
    assign any_strobe = !(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n);

    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~chan_ack_n));

    assert_strobe_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> any_ack);

    assert_mem_rw_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    assert_ack_needs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_ack |-> hold_req);

    assert_release_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&chan_ack_n) |-> !hold_req);

    assert_tc_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_xfer |-> any_ack);

    assert_status_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> (reg_rdata[7:N_CH] == '0));
endmodule

bind quad_dma_engine dma4_checker #(.N_CH(N_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .chan_ack_n (chan_ack_n),
    .hold_req   (hold_req),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .io_rd_n    (io_rd_n),
    .io_wr_n    (io_wr_n),
    .last_xfer  (last_xfer)
);

// File: tb/quad_dma_engine_tb_top.sv
module quad_dma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [3:0]  chan_req = '0;
    logic [3:0]  chan_ack_n;
    logic        hold_req;
    logic        hold_ack = 1'b0;
    logic [15:0] bus_addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, last_xfer;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  grant_en = 1'b0;
    int  mon_phase = 0;

    typedef struct {
        int          ch;
        logic [15:0] addr;
        bit          dir;
        bit          last;
    } xfer_t;
    xfer_t exp_q[$];
    xfer_t cur;

    always #5 clk = ~clk;

    quad_dma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_req(chan_req), .chan_ack_n(chan_ack_n), .hold_req(hold_req),
        .hold_ack(hold_ack), .bus_addr(bus_addr), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .last_xfer(last_xfer)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // Processor model: grants the bus one cycle after it is asked, when allowed.
    initial begin
        forever begin
            @(posedge clk);
            #1 hold_ack = hold_req && grant_en;
        end
    end

    // Monitor: pops one expected transfer per acknowledge window.
    initial begin
        logic [3:0] strb;
        logic [3:0] strb_exp;
        forever begin
            @(negedge clk);
            strb = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
            if (chan_ack_n != 4'hF) begin
                mon_phase++;
                if (mon_phase == 1) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected transfer ack", {28'd0, chan_ack_n}, 32'hF);
                        cur = '{ch: 0, addr: 16'h0, dir: 1'b0, last: 1'b0};
                    end else begin
                        cur = exp_q.pop_front();
                    end
                    chk(chan_ack_n == ~(4'b1 << cur.ch), "R4", "granted ack", {28'd0, chan_ack_n}, {28'd0, ~(4'b1 << cur.ch)});
                    chk(bus_addr == cur.addr, "R7", "transfer address", {16'd0, bus_addr}, {16'd0, cur.addr});
                end
                strb_exp = 4'hF;
                if (mon_phase == 2 || mon_phase == 3) begin
                    strb_exp = cur.dir ? 4'b0110 : 4'b1001;
                end
                chk(strb == strb_exp && chan_ack_n == ~(4'b1 << cur.ch) && bus_addr == cur.addr,
                    "R5", "strobes/ack/addr per cycle", {12'd0, strb, bus_addr}, {12'd0, strb_exp, cur.addr});
                chk(last_xfer == cur.last, "R8", "terminal count output", {31'd0, last_xfer}, {31'd0, cur.last});
            end else if (mon_phase != 0) begin
                chk(mon_phase == 4, "R5", "ack window length", mon_phase, 4);
                chk(!hold_req, "R6", "hold dropped after transfer", {31'd0, hold_req}, 0);
                mon_phase = 0;
            end
        end
    end

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] d);
        @(posedge clk); #1;
        reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // R2 encoding: address {ch,0}, count {ch,1}; count high bit7 = direction.
    task automatic program_ch(input int ch, input logic [15:0] a, input int n, input bit dir);
        logic [13:0] cnt;
        cnt = 14'(n - 1);
        host_write({ch[1:0], 1'b0}, a[7:0]);
        host_write({ch[1:0], 1'b0}, a[15:8]);
        host_write({ch[1:0], 1'b1}, cnt[7:0]);
        host_write({ch[1:0], 1'b1}, {dir, 1'b0, cnt[13:8]});
    endtask

    task automatic expect_block(input int ch, input logic [15:0] a, input int n, input bit dir);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{ch: ch, addr: a + 16'(i), dir: dir, last: (i == n - 1)});
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || mon_phase != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit stayed;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(chan_ack_n == 4'hF, "R1", "acks after reset", {28'd0, chan_ack_n}, 32'hF);
        chk(!hold_req, "R1", "hold after reset", {31'd0, hold_req}, 0);
        chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF, "R1", "strobes after reset",
            {28'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 32'hF);
        chk(!last_xfer, "R1", "tc after reset", {31'd0, last_xfer}, 0);
        host_read(rd);
        chk(rd == 8'h00, "R1", "status after reset", {24'd0, rd}, 0);

        // R11 unarmed channel request is ignored
        chan_req = 4'b0010;
        stayed = 1'b1;
        repeat (8) begin @(negedge clk); if (hold_req) stayed = 1'b0; end
        chk(stayed, "R11", "unarmed request kept hold low", {31'd0, !stayed}, 0);
        chan_req = 4'b0000;

        // R2/R5/R7: three-byte block on channel 2, memory to peripheral
        grant_en = 1'b1;
        program_ch(2, 16'h1234, 3, 1'b1);
        expect_block(2, 16'h1234, 3, 1'b1);
        chan_req = 4'b0100;
        drain();
        chan_req = 4'b0000;
        host_read(rd);
        chk(rd == 8'h04, "R9", "status after ch2 block", {24'd0, rd}, 32'h04);
        host_read(rd);
        chk(rd == 8'h00, "R9", "status cleared by read", {24'd0, rd}, 0);
        // R7: expired channel ignores its request
        chan_req = 4'b0100;
        stayed = 1'b1;
        repeat (8) begin @(negedge clk); if (hold_req) stayed = 1'b0; end
        chk(stayed, "R7", "expired channel ignored", {31'd0, !stayed}, 0);
        chan_req = 4'b0000;

        // R4 priority: ch0 and ch3 request together; ch3 crosses top of memory
        program_ch(3, 16'hFFFE, 2, 1'b1);
        program_ch(0, 16'h0100, 1, 1'b0);
        expect_block(0, 16'h0100, 1, 1'b0);
        expect_block(3, 16'hFFFE, 2, 1'b1);
        chan_req = 4'b1001;
        drain();
        chan_req = 4'b0000;
        host_read(rd);
        chk(rd == 8'h09, "R9", "status after ch0 and ch3", {24'd0, rd}, 32'h09);

        // R3/R10: no transfer before hold_ack; writes while holding are ignored
        program_ch(1, 16'h4000, 1, 1'b0);
        grant_en = 1'b0;
        expect_block(1, 16'h4000, 1, 1'b0);
        chan_req = 4'b0010;
        @(posedge clk);
        @(negedge clk);
        chk(hold_req, "R3", "hold raised next cycle", {31'd0, hold_req}, 1);
        stayed = 1'b1;
        repeat (6) begin @(negedge clk); if (chan_ack_n != 4'hF || !hold_req) stayed = 1'b0; end
        chk(stayed, "R3", "waiting for hold_ack without ack", {28'd0, chan_ack_n}, 32'hF);
        host_write(3'b010, 8'h55);
        grant_en = 1'b1;
        drain();
        chan_req = 4'b0000;
        // R10: a toggled pointer would misalign this block
        program_ch(1, 16'h6000, 1, 1'b1);
        expect_block(1, 16'h6000, 1, 1'b1);
        chan_req = 4'b0010;
        drain();
        chan_req = 4'b0000;

        // R2: a lone low byte, then a status read re-aligns the pointer
        host_write(3'b000, 8'hAA);
        host_read(rd);
        chk(rd == 8'h02, "R9", "status after ch1 blocks", {24'd0, rd}, 32'h02);
        program_ch(0, 16'h2000, 1, 1'b1);
        expect_block(0, 16'h2000, 1, 1'b1);
        chan_req = 4'b0001;
        // R9: read in the same cycle the terminal count is recorded
        do begin @(posedge clk); #1; end while (chan_ack_n == 4'hF);
        repeat (3) begin @(posedge clk); #1; end
        reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        chk(reg_rdata == 8'h00, "R9", "collision read returns old status", {24'd0, reg_rdata}, 0);
        drain();
        chan_req = 4'b0000;
        host_read(rd);
        chk(rd == 8'h01, "R9", "flag set during read survives", {24'd0, rd}, 32'h01);

        chk(exp_q.size() == 0, "R7", "all expected transfers seen", exp_q.size(), 0);
        report();
        $finish;
    end
endmodule